// File: doc/BRIEF.md
# Power-domain switch sequencer

This controller brings a gated logic domain between its collapsed and its powered state through a fixed sequence of steps. A request interface with a direction bit asks for power-up or power-down. The controller then works through the steps one at a time. It halts or releases the domain's bus ports through a request/acknowledge pair per port. It drives one reset line per clock of the domain, the I/O clamp, the rail enable and a memory-retain flag. Each step ends with a one-cycle done pulse that carries a status code.

Every wait is a cycle count taken from a configuration input: the reset-propagation delay, the rail settle delay and the halt-handshake timeout. Each wait is measured against a single free-running counter. The settle count must be set so that it covers at least 1 µs at the clock rate in use. A halt handshake that does not finish in time undoes the port work already done and ends the sequence with a timeout status. The rail and clamp are left untouched in that case. At power-on reset the domain is taken to be collapsed.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, clampOut=1, railEn=0, every domainRst bit is 1, every haltReq bit is 1, retainMem=1, reqReady=1, doneValid=0 and doneStatus=0.
- R2: A request is accepted when reqValid=1 and reqReady=1 at a clock edge. Some requests need no work: power-up (reqUp=1) while railEn=1 and clampOut=0, and power-down (reqUp=0) while railEn=0. Such a request gives doneValid with status 0 one cycle after acceptance, changes no other output, and never raises busy.
- R3: On power-down, retainMem falls at acceptance. One cycle later haltReq[0] rises. Each further port's haltReq rises in ascending index order, in the cycle after the previous port's haltAck is seen high.
- R4: After the last halt acknowledge, domainRst bits are asserted one per cycle, from the highest index down to index 0. There is then a wait of cfgRstDelay cycles (a value of 0 counts as 1), after which clampOut rises. One cycle later railEn falls, together with a done pulse of status 0.
- R5: If a power-down haltAck stays low for cfgHaltTimeout cycles, the sequence stops. All haltReq bits drop, including those of ports already acknowledged. retainMem returns to 1, the done status is 1 (timeout), and railEn and clampOut are unchanged.
- R6: On power-up, haltReq bits drop in ascending order, each in the cycle after the previous port's haltAck is seen low. Then domainRst bits are asserted from the highest index down to 0. After cfgRstDelay cycles railEn rises, and clampOut falls cfgSettleDelay cycles later.
- R7: After the clamp is released, domainRst bits drop one per cycle from index 0 upward. Then retainMem is set and a done pulse with status 0 is given.
- R8: With cfgCorePulse=1, after the upward release, domainRst[0] (the core reset) is asserted once more for cfgRstDelay cycles and released. A further cfgRstDelay cycles pass before the done pulse.
- R9: If a power-up haltAck stays high for cfgHaltTimeout cycles, all haltReq bits return to 1 (ports re-halted) and the done status is 1. The rail, clamp and resets keep the state they had at that point.
- R10: From acceptance until the done pulse, reqReady is 0 and domainState[2] is 1. Requests presented during that time are ignored.
- R11: doneValid lasts one cycle and doneStatus holds 0 for success and 1 for a halt timeout. domainState is {busy, clampOut, railEn}, with bit 2 for busy and bit 0 for rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Sequence request |
| reqUp | input | 1 | 1 = power up, 0 = power down |
| reqReady | output | 1 | High while idle, a request is taken |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 1 | 0 success, 1 halt timeout |
| cfgRstDelay | input | CNT_W | Reset propagation wait in cycles |
| cfgSettleDelay | input | CNT_W | Rail settle wait in cycles |
| cfgHaltTimeout | input | CNT_W | Halt handshake timeout in cycles |
| cfgCorePulse | input | 1 | Extra core reset pulse after power-up |
| haltReq | output | NUM_PORTS | Bus-port halt request per port |
| haltAck | input | NUM_PORTS | Bus-port halt acknowledge per port |
| domainRst | output | NUM_RSTS | Reset per domain clock, 1 = asserted, bit 0 is core |
| clampOut | output | 1 | I/O clamp, 1 = clamped |
| railEn | output | 1 | Rail enable |
| retainMem | output | 1 | Memory retention flag |
| domainState | output | 3 | {busy, clamped, powered} |

## Verification
On every cycle, the assertions check the ordering invariants. The rail may only fall after the clamp has been set, with all ports halted and all resets asserted. The rail may only rise, and the clamp only release, while every reset is held. At most one reset line may change per cycle. The retain flag may only drop while no port is halted, and a timeout done must leave the ports fully rolled back. The exact step timing needs the bench's scenarios and its cycle-accurate model. Those scenarios cover the length of each programmed wait, the no-op cases, requests ignored while busy, the optional core pulse, and which ports are rolled back after a stuck acknowledge.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DROPRET, S_HALT, S_UNHALT, S_RSTON, S_WAITRST, S_RAILOFF,
    S_SETTLE, S_RSTOFF, S_PULSEON, S_PULSEWAIT, S_PULSEGAP
  } seqState_t;

  // strobes from the sequencer to the output registers
  typedef struct packed {
    logic timerMark;
    logic haltSet;
    logic haltClr;
    logic haltAllSet;
    logic haltAllClr;
    logic rstSet;
    logic rstClr;
    logic coreRstSet;
    logic coreRstClr;
    logic clampSet;
    logic clampClr;
    logic railSet;
    logic railClr;
    logic retainSet;
    logic retainClr;
    logic doneOk;
    logic doneFail;
  } seqStrobe_t;

  localparam logic STATUS_OK      = 1'b0;
  localparam logic STATUS_TIMEOUT = 1'b1;

endpackage

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_RSTS  = 3,
  parameter int CNT_W     = 16,
  localparam int PORT_IW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int RST_IW   = (NUM_RSTS > 1) ? $clog2(NUM_RSTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqUp,
  output logic                 reqReady,
  output logic                 busy,
  input  logic [NUM_PORTS-1:0] haltAck,
  input  logic [CNT_W-1:0]     cfgRstDelay,
  input  logic [CNT_W-1:0]     cfgSettleDelay,
  input  logic [CNT_W-1:0]     cfgHaltTimeout,
  input  logic                 cfgCorePulse,
  input  logic [CNT_W-1:0]     elapsed,
  input  logic                 railOn,
  input  logic                 clampOn,
  output seqStrobe_t           stb,
  output logic [PORT_IW-1:0]   portIdx,
  output logic [RST_IW-1:0]    rstIdx
);

  localparam logic [PORT_IW-1:0] LAST_PORT = PORT_IW'(NUM_PORTS - 1);
  localparam logic [RST_IW-1:0]  LAST_RST  = RST_IW'(NUM_RSTS - 1);

  seqState_t state, nState;
  logic [PORT_IW-1:0] pIdx, nPIdx;
  logic [RST_IW-1:0]  rIdx, nRIdx;
  logic dirUp, nDirUp;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   elapsedP1;
  logic timeUp;

  always_comb begin
    case (state)
      S_HALT, S_UNHALT: limit = cfgHaltTimeout;
      S_SETTLE:         limit = cfgSettleDelay;
      default:          limit = cfgRstDelay;
    endcase
  end

  assign elapsedP1 = {1'b0, elapsed} + (CNT_W + 1)'(1);
  assign timeUp    = elapsedP1 >= {1'b0, limit};

  always_comb begin
    stb    = '0;
    nState = state;
    nPIdx  = pIdx;
    nRIdx  = rIdx;
    nDirUp = dirUp;
    case (state)
      S_IDLE: if (reqValid) begin
        if (reqUp) begin
          if (railOn && !clampOn) stb.doneOk = 1'b1;
          else begin
            nState = S_UNHALT; nDirUp = 1'b1; nPIdx = '0;
            stb.haltClr = 1'b1; stb.timerMark = 1'b1;
          end
        end else begin
          if (!railOn) stb.doneOk = 1'b1;
          else begin
            nState = S_DROPRET; nDirUp = 1'b0; nPIdx = '0;
            stb.retainClr = 1'b1;
          end
        end
      end
      S_DROPRET: begin
        stb.haltSet = 1'b1; stb.timerMark = 1'b1; nState = S_HALT;
      end
      S_HALT, S_UNHALT: begin
        if (haltAck[pIdx] == (state == S_HALT)) begin
          if (pIdx == LAST_PORT) begin
            nState = S_RSTON; nRIdx = LAST_RST;
          end else begin
            nPIdx = pIdx + PORT_IW'(1);
            stb.timerMark = 1'b1;
            if (state == S_HALT) stb.haltSet = 1'b1;
            else                 stb.haltClr = 1'b1;
          end
        end else if (timeUp) begin
          stb.doneFail = 1'b1;
          nState = S_IDLE;
          if (state == S_HALT) begin
            stb.haltAllClr = 1'b1; stb.retainSet = 1'b1;
          end else begin
            stb.haltAllSet = 1'b1;
          end
        end
      end
      S_RSTON: begin
        stb.rstSet = 1'b1;
        if (rIdx == '0) begin
          nState = S_WAITRST; stb.timerMark = 1'b1;
        end else nRIdx = rIdx - RST_IW'(1);
      end
      S_WAITRST: if (timeUp) begin
        if (dirUp) begin
          stb.railSet = 1'b1; stb.timerMark = 1'b1; nState = S_SETTLE;
        end else begin
          stb.clampSet = 1'b1; nState = S_RAILOFF;
        end
      end
      S_RAILOFF: begin
        stb.railClr = 1'b1; stb.doneOk = 1'b1; nState = S_IDLE;
      end
      S_SETTLE: if (timeUp) begin
        stb.clampClr = 1'b1; nState = S_RSTOFF; nRIdx = '0;
      end
      S_RSTOFF: begin
        stb.rstClr = 1'b1;
        if (rIdx == LAST_RST) begin
          if (cfgCorePulse) nState = S_PULSEON;
          else begin
            stb.retainSet = 1'b1; stb.doneOk = 1'b1; nState = S_IDLE;
          end
        end else nRIdx = rIdx + RST_IW'(1);
      end
      S_PULSEON: begin
        stb.coreRstSet = 1'b1; stb.timerMark = 1'b1; nState = S_PULSEWAIT;
      end
      S_PULSEWAIT: if (timeUp) begin
        stb.coreRstClr = 1'b1; stb.timerMark = 1'b1; nState = S_PULSEGAP;
      end
      S_PULSEGAP: if (timeUp) begin
        stb.retainSet = 1'b1; stb.doneOk = 1'b1; nState = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      pIdx  <= '0;
      rIdx  <= '0;
      dirUp <= 1'b0;
    end else begin
      state <= nState;
      pIdx  <= nPIdx;
      rIdx  <= nRIdx;
      dirUp <= nDirUp;
    end
  end

  assign portIdx  = nPIdx;
  assign rstIdx   = rIdx;
  assign reqReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);

endmodule

// File: rtl/pds_dpath.sv
module pds_dpath
  import pds_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_RSTS  = 3,
  parameter int CNT_W     = 16,
  localparam int PORT_IW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int RST_IW   = (NUM_RSTS > 1) ? $clog2(NUM_RSTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  logic [PORT_IW-1:0]   portIdx,
  input  logic [RST_IW-1:0]    rstIdx,
  output logic [CNT_W-1:0]     elapsed,
  output logic [NUM_PORTS-1:0] haltReq,
  output logic [NUM_RSTS-1:0]  domainRst,
  output logic                 clampOut,
  output logic                 railEn,
  output logic                 retainMem,
  output logic                 doneValid,
  output logic                 doneStatus
);

  logic [CNT_W-1:0] freeCnt, markCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeCnt <= '0;
      markCnt <= '0;
    end else begin
      freeCnt <= freeCnt + CNT_W'(1);
      if (stb.timerMark) markCnt <= freeCnt + CNT_W'(1);
    end
  end

  assign elapsed = freeCnt - markCnt;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      haltReq[i] <= 1'b1;
      else if (stb.haltAllSet)                        haltReq[i] <= 1'b1;
      else if (stb.haltAllClr)                        haltReq[i] <= 1'b0;
      else if (stb.haltSet && portIdx == PORT_IW'(i)) haltReq[i] <= 1'b1;
      else if (stb.haltClr && portIdx == PORT_IW'(i)) haltReq[i] <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_RSTS; i++) begin : g_rst
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    domainRst[i] <= 1'b1;
      else if (i == 0 && stb.coreRstSet)            domainRst[i] <= 1'b1;
      else if (i == 0 && stb.coreRstClr)            domainRst[i] <= 1'b0;
      else if (stb.rstSet && rstIdx == RST_IW'(i))  domainRst[i] <= 1'b1;
      else if (stb.rstClr && rstIdx == RST_IW'(i))  domainRst[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clampOut   <= 1'b1;
      railEn     <= 1'b0;
      retainMem  <= 1'b1;
      doneValid  <= 1'b0;
      doneStatus <= STATUS_OK;
    end else begin
      if (stb.clampSet)       clampOut  <= 1'b1;
      else if (stb.clampClr)  clampOut  <= 1'b0;
      if (stb.railSet)        railEn    <= 1'b1;
      else if (stb.railClr)   railEn    <= 1'b0;
      if (stb.retainSet)      retainMem <= 1'b1;
      else if (stb.retainClr) retainMem <= 1'b0;
      doneValid <= stb.doneOk | stb.doneFail;
      if (stb.doneOk | stb.doneFail)
        doneStatus <= stb.doneFail ? STATUS_TIMEOUT : STATUS_OK;
    end
  end

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_RSTS  = 3,
  parameter int CNT_W     = 16,
  localparam int PORT_IW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int RST_IW   = (NUM_RSTS > 1) ? $clog2(NUM_RSTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqUp,
  output logic                 reqReady,
  output logic                 doneValid,
  output logic                 doneStatus,
  input  logic [CNT_W-1:0]     cfgRstDelay,
  input  logic [CNT_W-1:0]     cfgSettleDelay,
  input  logic [CNT_W-1:0]     cfgHaltTimeout,
  input  logic                 cfgCorePulse,
  output logic [NUM_PORTS-1:0] haltReq,
  input  logic [NUM_PORTS-1:0] haltAck,
  output logic [NUM_RSTS-1:0]  domainRst,
  output logic                 clampOut,
  output logic                 railEn,
  output logic                 retainMem,
  output logic [2:0]           domainState
);

  seqStrobe_t          stb;
  logic [PORT_IW-1:0]  portIdx;
  logic [RST_IW-1:0]   rstIdx;
  logic [CNT_W-1:0]    elapsed;
  logic                busy;

  pds_ctrl #(.NUM_PORTS(NUM_PORTS), .NUM_RSTS(NUM_RSTS), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .reqValid, .reqUp, .reqReady, .busy, .haltAck,
    .cfgRstDelay, .cfgSettleDelay, .cfgHaltTimeout, .cfgCorePulse,
    .elapsed, .railOn(railEn), .clampOn(clampOut),
    .stb, .portIdx, .rstIdx
  );

  pds_dpath #(.NUM_PORTS(NUM_PORTS), .NUM_RSTS(NUM_RSTS), .CNT_W(CNT_W)) u_dpath (
    .clk, .rstN, .stb, .portIdx, .rstIdx, .elapsed,
    .haltReq, .domainRst, .clampOut, .railEn, .retainMem,
    .doneValid, .doneStatus
  );

  assign domainState = {busy, clampOut, railEn};

endmodule

// File: rtl/pwr_domain_seq_chk.sv
module pwr_domain_seq_chk #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_RSTS  = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 doneValid,
  input logic                 doneStatus,
  input logic [NUM_PORTS-1:0] haltReq,
  input logic [NUM_RSTS-1:0]  domainRst,
  input logic                 clampOut,
  input logic                 railEn,
  input logic                 retainMem,
  input logic [2:0]           domainState
);

  AST_RETAIN_BEFORE_HALT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(retainMem) |-> (haltReq == '0) && railEn); // R3

  AST_CLAMP_LEADS_RAIL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(railEn) |-> $past(clampOut) && clampOut); // R4

  AST_COLLAPSE_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(railEn) |-> (&haltReq) && (&domainRst)); // R4

  AST_RST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $countones(domainRst ^ $past(domainRst)) <= 1); // R7

  AST_RAIL_ON_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(railEn) |-> clampOut && (&domainRst) && (haltReq == '0)); // R6

  AST_UNCLAMP_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clampOut) |-> railEn && $past(railEn) && (&domainRst)); // R6

  AST_FAIL_ROLLBACK: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneStatus |-> ((haltReq == '0) && retainMem) || (&haltReq)); // R5 R9

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(domainState[2]) |-> $past(reqValid)); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> reqReady && !domainState[2]); // R11

endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(.NUM_PORTS(NUM_PORTS), .NUM_RSTS(NUM_RSTS)) u_chk (.*);

// File: tb/pwr_domain_seq_tb.sv
module pwr_domain_seq_tb;
  localparam int NP = 2;
  localparam int NR = 3;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqUp = 1'b0;
  logic [CW-1:0] cfgRstDelay = 16'd4, cfgSettleDelay = 16'd6, cfgHaltTimeout = 16'd5;
  logic cfgCorePulse = 1'b0;
  logic [NP-1:0] haltAck = '1;
  logic reqReady, doneValid, doneStatus, clampOut, railEn, retainMem;
  logic [NP-1:0] haltReq;
  logic [NR-1:0] domainRst;
  logic [2:0] domainState;

  pwr_domain_seq #(.NUM_PORTS(NP), .NUM_RSTS(NR), .CNT_W(CW)) u_dut (
    .clk, .rstN, .reqValid, .reqUp, .reqReady, .doneValid, .doneStatus,
    .cfgRstDelay, .cfgSettleDelay, .cfgHaltTimeout, .cfgCorePulse,
    .haltReq, .haltAck, .domainRst, .clampOut, .railEn, .retainMem, .domainState
  );

  int errors = 0, checks = 0, cyc = 0;
  string curReq = "R1";
  bit cmpOn = 1'b0;

  // port responder: acknowledge follows request after lat cycles unless stuck
  int lat[NP] = '{2, 3};
  bit stuck[NP] = '{1'b0, 1'b0};
  int rcnt[NP] = '{0, 0};
  always @(negedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (!rstN) begin haltAck[i] = 1'b1; rcnt[i] = 0; end
      else if (stuck[i] || haltAck[i] == haltReq[i]) rcnt[i] = 0;
      else begin
        rcnt[i]++;
        if (rcnt[i] >= lat[i]) begin haltAck[i] = haltReq[i]; rcnt[i] = 0; end
      end
    end
  end

  // behavioural reference model, advanced at every rising edge
  logic [NP-1:0] eHalt;
  logic [NR-1:0] eRst;
  logic eClamp, eRail, eRetain, eDone, eStatus, eBusy;

  function automatic int atLeast1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic tick();
    @(posedge clk);
    eDone = 1'b0;
  endtask

  task automatic waitCyc(int d);
    repeat (atLeast1(d)) tick();
  endtask

  task automatic finishSeq(logic st);
    eDone = 1'b1; eStatus = st; eBusy = 1'b0;
  endtask

  task automatic runSeq(logic up);
    logic tgt;
    int cnt;
    if ((up && eRail && !eClamp) || (!up && !eRail)) begin
      eDone = 1'b1; eStatus = 1'b0; return;
    end
    eBusy = 1'b1;
    tgt = !up;
    if (!up) begin eRetain = 1'b0; tick(); end
    eHalt[0] = tgt;
    for (int p = 0; p < NP; p++) begin
      cnt = 0;
      forever begin
        tick();
        if (haltAck[p] == tgt) begin
          if (p < NP - 1) eHalt[p+1] = tgt;
          break;
        end
        cnt++;
        if (cnt >= atLeast1(int'(cfgHaltTimeout))) begin
          if (up) eHalt = '1;
          else begin eHalt = '0; eRetain = 1'b1; end
          finishSeq(1'b1);
          return;
        end
      end
    end
    for (int k = NR - 1; k >= 0; k--) begin tick(); eRst[k] = 1'b1; end
    waitCyc(int'(cfgRstDelay));
    if (!up) begin
      eClamp = 1'b1; tick(); eRail = 1'b0; finishSeq(1'b0); return;
    end
    eRail = 1'b1;
    waitCyc(int'(cfgSettleDelay));
    eClamp = 1'b0;
    for (int k = 0; k < NR; k++) begin tick(); eRst[k] = 1'b0; end
    if (cfgCorePulse) begin
      tick(); eRst[0] = 1'b1;
      waitCyc(int'(cfgRstDelay)); eRst[0] = 1'b0;
      waitCyc(int'(cfgRstDelay));
    end
    eRetain = 1'b1;
    finishSeq(1'b0);
  endtask

  initial begin : model
    eHalt = '1; eRst = '1; eClamp = 1'b1; eRail = 1'b0; eRetain = 1'b1;
    eDone = 1'b0; eStatus = 1'b0; eBusy = 1'b0;
    forever begin
      tick();
      if (rstN && !eBusy && reqValid) runSeq(reqUp);
    end
  end

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, nm, act, exp, $time);
    end
  endtask

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      chk(curReq, "haltReq", 32'(haltReq), 32'(eHalt));
      chk(curReq, "domainRst", 32'(domainRst), 32'(eRst));
      chk(curReq, "clampOut", 32'(clampOut), 32'(eClamp));
      chk(curReq, "railEn", 32'(railEn), 32'(eRail));
      chk(curReq, "retainMem", 32'(retainMem), 32'(eRetain));
      chk("R11", "doneValid", 32'(doneValid), 32'(eDone));
      chk("R11", "doneStatus", 32'(doneStatus), 32'(eStatus));
      chk("R10", "reqReady", 32'(reqReady), 32'(!eBusy));
      chk("R11", "domainState", 32'(domainState), 32'({eBusy, eClamp, eRail}));
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
    end
  end

  task automatic doReq(logic up);
    @(negedge clk); reqValid = 1'b1; reqUp = up;
    @(negedge clk); reqValid = 1'b0;
  endtask

  task automatic waitDone(string req, logic expStatus);
    while (doneValid !== 1'b1) @(negedge clk);
    chk(req, "done status", 32'(doneStatus), 32'(expStatus));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1'b1;
    // R1 reset state
    chk("R1", "clampOut", 32'(clampOut), 32'd1);
    chk("R1", "railEn", 32'(railEn), 32'd0);
    chk("R1", "domainRst", 32'(domainRst), 32'h7);
    chk("R1", "haltReq", 32'(haltReq), 32'h3);
    chk("R1", "retainMem", 32'(retainMem), 32'd1);
    chk("R1", "reqReady", 32'(reqReady), 32'd1);
    idle(2);

    // R2 power-down while collapsed is a no-op
    curReq = "R2"; doReq(1'b0); waitDone("R2", 1'b0);
    chk("R2", "rail stays off", 32'(railEn), 32'd0);
    idle(3);

    // R6 R7 power-up, no core pulse
    curReq = "R6"; cfgRstDelay = 16'd4; cfgSettleDelay = 16'd6; cfgCorePulse = 1'b0;
    doReq(1'b1); waitDone("R7", 1'b0);
    chk("R7", "rail on", 32'(railEn), 32'd1);
    chk("R7", "resets released", 32'(domainRst), 32'd0);
    idle(3);

    // R2 power-up while powered is a no-op
    curReq = "R2"; doReq(1'b1); waitDone("R2", 1'b0);
    idle(3);

    // R3 R4 power-down
    curReq = "R3"; doReq(1'b0); waitDone("R4", 1'b0);
    chk("R4", "clamped", 32'(clampOut), 32'd1);
    chk("R3", "retain dropped", 32'(retainMem), 32'd0);
    idle(3);

    // R8 power-up with extra core reset pulse
    curReq = "R8"; cfgRstDelay = 16'd3; cfgCorePulse = 1'b1;
    doReq(1'b1); waitDone("R8", 1'b0);
    chk("R8", "retain set", 32'(retainMem), 32'd1);
    idle(3);

    // R5 power-down with port 1 never acknowledging
    curReq = "R5"; cfgHaltTimeout = 16'd5; stuck[1] = 1'b1;
    doReq(1'b0); waitDone("R5", 1'b1);
    chk("R5", "halts withdrawn", 32'(haltReq), 32'd0);
    chk("R5", "rail kept", 32'(railEn), 32'd1);
    stuck[1] = 1'b0; idle(8);

    // R4 boundary: reset delay of zero
    curReq = "R4"; cfgRstDelay = 16'd0; cfgCorePulse = 1'b0;
    doReq(1'b0); waitDone("R4", 1'b0);
    idle(3);

    // R9 power-up with port 1 stuck halted
    curReq = "R9"; cfgRstDelay = 16'd2; stuck[1] = 1'b1;
    doReq(1'b1); waitDone("R9", 1'b1);
    chk("R9", "ports re-halted", 32'(haltReq), 32'h3);
    chk("R9", "rail still off", 32'(railEn), 32'd0);
    stuck[1] = 1'b0; idle(8);

    // R10 requests ignored while busy
    curReq = "R10"; cfgRstDelay = 16'd20;
    doReq(1'b1);
    idle(4);
    reqValid = 1'b1; reqUp = 1'b0;
    idle(3);
    chk("R10", "reqReady while busy", 32'(reqReady), 32'd0);
    reqValid = 1'b0;
    waitDone("R10", 1'b0);
    idle(10);
    chk("R10", "power-down ignored", 32'(railEn), 32'd1);

    idle(2);
    summary();
  end
endmodule